// File: doc/BRIEF.md
# Systolic Horner Polynomial Evaluator

This block evaluates a polynomial of fixed degree N at a stream of fixed-point sample points. The work is spread along a one-dimensional chain of N stages. Each stage is a pair of elements: a multiplier that scales the partial sum arriving from its left by the sample's x, and an adder that adds that stage's coefficient. Every partial result is registered and handed only to the right-hand neighbour. The leading coefficient seeds the chain, and the last adder applies the constant term. One sample point may enter on every clock, and one result leaves per clock after a fixed latency.

The value of x travels beside its partial sum through a delay register in each stage, so every multiplier uses the x of the sample it is working on. Coefficients are written one at a time through a write port. A write moves down the chain in step with the samples, so samples already in flight finish with the old set and later samples see the new one. The arithmetic is signed two's complement with FRAC_W fraction bits. Each product is scaled back by an arithmetic right shift and truncated to the data width. Overflow wraps and is never saturated.

Top module: `hornerArray`

## Requirements
- R1: A sample presented with inValid high in cycle t produces outValid high in cycle t+2·DEGREE, and in no other cycle. A new sample may be presented in every cycle.
- R2: y equals Horner's rule run in the order acc = a_N, then for k = N-1 down to 0: acc = wrap(trunc((acc·x) >>> FRAC_W)) + a_k. The shift is arithmetic, the kept bits are the low DATA_W bits, and the addition also wraps modulo 2^DATA_W (signed two's complement).
- R3: A write with coefWe high, coefAddr = i (0 ≤ i ≤ DEGREE) and coefData = v sets coefficient a_i to v. a_DEGREE is the leading coefficient and a_0 the constant term.
- R4: A coefficient write sampled on the same clock edge as a sample is not used by that sample, or by any earlier sample still in the chain. It is used by every sample that enters on a later edge.
- R5: A synchronous reset clears every valid bit: outValid is low from the cycle after reset is sampled, samples in flight are dropped, and every coefficient becomes zero.
- R6: While outValid is low, y keeps the last result it showed, including during and after reset.
- R7: Cycles with inValid low create bubbles that keep their positions, so results leave in the same spacing in which samples entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample point strobe |
| x | input | DATA_W | Signed fixed-point sample point |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | ADDR_W | Coefficient index, 0 to DEGREE |
| coefData | input | DATA_W | Signed fixed-point coefficient value |
| outValid | output | 1 | Result strobe |
| y | output | DATA_W | Signed fixed-point polynomial value |

## Verification
The assertions assume that a coefficient write never names an index above DEGREE, and that reset is held for at least one edge before the first sample. The latency and hold properties also assume that inValid and coefWe are driven to known values on every edge after reset. The stimulus writes only indices 0 to DEGREE and holds reset for several cycles at the start. It changes its inputs only on the falling edge, so no input is undefined when the design samples it.

// File: rtl/hornerPkg.sv
package hornerPkg;

  // Per-stage strobes from control to datapath.
  typedef struct packed {
    logic mulEn;     // multiplier register captures this cycle
    logic addEn;     // adder register captures this cycle
    logic coefLoad;  // stage coefficient takes the travelling write
  } stageCtlT;

endpackage

// File: rtl/hornerCtl.sv
module hornerCtl #(
  parameter int DEGREE = 4,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic                  coefWe,
  input  logic [ADDR_W-1:0]     coefAddr,
  output logic                  headLoad,
  output hornerPkg::stageCtlT   stageCtl [DEGREE],
  output logic                  outValid
);

  // The leading coefficient is read at chain entry, so it loads at once.
  assign headLoad = coefWe && !rst && (coefAddr == ADDR_W'(DEGREE));

  genvar i;
  generate
    for (i = 0; i < DEGREE; i++) begin : g_stage
      logic              feedValid;
      logic              feedWe;
      logic [ADDR_W-1:0] feedAddr;
      logic              mulV;
      logic              addV;
      logic              tokWe;
      logic [ADDR_W-1:0] tokAddr;

      if (i == 0) begin : g_head
        assign feedValid = inValid;
        assign feedWe    = coefWe;
        assign feedAddr  = coefAddr;
      end else begin : g_link
        // write token position alongside the previous adder
        logic              tokWeAdd;
        logic [ADDR_W-1:0] tokAddrAdd;
        always_ff @(posedge clk) begin
          if (rst) begin
            tokWeAdd   <= 1'b0;
            tokAddrAdd <= '0;
          end else begin
            tokWeAdd   <= g_stage[i-1].tokWe;
            tokAddrAdd <= g_stage[i-1].tokAddr;
          end
        end
        assign feedValid = g_stage[i-1].addV;
        assign feedWe    = tokWeAdd;
        assign feedAddr  = tokAddrAdd;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mulV    <= 1'b0;
          addV    <= 1'b0;
          tokWe   <= 1'b0;
          tokAddr <= '0;
        end else begin
          mulV    <= feedValid;
          addV    <= mulV;
          tokWe   <= feedWe;
          tokAddr <= feedAddr;
        end
      end

      assign stageCtl[i].mulEn    = feedValid && !rst;
      assign stageCtl[i].addEn    = mulV && !rst;
      assign stageCtl[i].coefLoad = tokWe && !rst &&
                                    (tokAddr == ADDR_W'(DEGREE - 1 - i));
    end
  endgenerate

  assign outValid = g_stage[DEGREE-1].addV;

endmodule

// File: rtl/hornerDp.sv
module hornerDp #(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [DATA_W-1:0]   x,
  input  logic signed [DATA_W-1:0]   coefData,
  input  logic                       headLoad,
  input  hornerPkg::stageCtlT        stageCtl [DEGREE],
  output logic signed [DATA_W-1:0]   y
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] headCoef;

  always_ff @(posedge clk) begin
    if (rst)           headCoef <= '0;
    else if (headLoad) headCoef <= coefData;
  end

  genvar i;
  generate
    for (i = 0; i < DEGREE; i++) begin : g_stage
      logic signed [DATA_W-1:0] leftAcc;
      logic signed [DATA_W-1:0] leftX;
      logic signed [DATA_W-1:0] feedTok;
      logic signed [DATA_W-1:0] tokMul;
      logic signed [DATA_W-1:0] coefR;
      logic signed [DATA_W-1:0] mulR;
      logic signed [DATA_W-1:0] accR;
      logic signed [PROD_W-1:0] prod;

      if (i == 0) begin : g_head
        assign leftAcc = headCoef;
        assign leftX   = x;
        assign feedTok = coefData;
      end else begin : g_link
        // x and write data delayed through the previous pair
        logic signed [DATA_W-1:0] xMulPrev;
        logic signed [DATA_W-1:0] xAddPrev;
        logic signed [DATA_W-1:0] tokAddPrev;
        always_ff @(posedge clk) begin
          if (stageCtl[i-1].mulEn) xMulPrev <= g_stage[i-1].leftX;
          if (stageCtl[i-1].addEn) xAddPrev <= xMulPrev;
          tokAddPrev <= g_stage[i-1].tokMul;
        end
        assign leftAcc = g_stage[i-1].accR;
        assign leftX   = xAddPrev;
        assign feedTok = tokAddPrev;
      end

      assign prod = leftAcc * leftX;

      always_ff @(posedge clk) begin
        tokMul <= feedTok;
        if (stageCtl[i].mulEn) mulR <= DATA_W'(prod >>> FRAC_W);
        if (stageCtl[i].addEn) accR <= mulR + coefR;
      end

      always_ff @(posedge clk) begin
        if (rst)                       coefR <= '0;
        else if (stageCtl[i].coefLoad) coefR <= tokMul;
      end
    end
  endgenerate

  assign y = g_stage[DEGREE-1].accR;

endmodule

// File: rtl/hornerArray.sv
module hornerArray #(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  localparam int ADDR_W = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] x,
  input  logic              coefWe,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output logic              outValid,
  output logic [DATA_W-1:0] y
);

  hornerPkg::stageCtlT stageCtl [DEGREE];
  logic                headLoad;

  hornerCtl #(
    .DEGREE (DEGREE),
    .ADDR_W (ADDR_W)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .headLoad (headLoad),
    .stageCtl (stageCtl),
    .outValid (outValid)
  );

  hornerDp #(
    .DEGREE (DEGREE),
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .x        (x),
    .coefData (coefData),
    .headLoad (headLoad),
    .stageCtl (stageCtl),
    .y        (y)
  );

endmodule

// File: rtl/hornerArrayChk.sv
module hornerArrayChk #(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              coefWe,
  input logic [ADDR_W-1:0] coefAddr,
  input logic              outValid,
  input logic [DATA_W-1:0] y
);

  localparam int TRAIL_W = 2 * DEGREE;

  // Independent record of inValid over the last 2*DEGREE cycles.
  logic [TRAIL_W-1:0] validTrail;

  always_ff @(posedge clk) begin
    if (rst) validTrail <= '0;
    else     validTrail <= TRAIL_W'({validTrail, inValid});
  end

  // R1 R7
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == validTrail[TRAIL_W-1]);

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);

  // R6
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(y));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    coefWe |-> (coefAddr <= ADDR_W'(DEGREE)));

endmodule

bind hornerArray hornerArrayChk #(
  .DEGREE (DEGREE),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .coefWe   (coefWe),
  .coefAddr (coefAddr),
  .outValid (outValid),
  .y        (y)
);

// File: tb/sim_hornerArray.sv
module sim_hornerArray;

  localparam int CLK_PERIOD = 10;
  localparam int DEG        = 4;
  localparam int W          = 16;
  localparam int F          = 8;
  localparam int AW         = $clog2(DEG + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [W-1:0]  x;
  logic          coefWe;
  logic [AW-1:0] coefAddr;
  logic [W-1:0]  coefData;
  logic          outValid;
  logic [W-1:0]  y;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hornerArray #(.DEGREE(DEG), .DATA_W(W), .FRAC_W(F)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .x(x), .coefWe(coefWe),
    .coefAddr(coefAddr), .coefData(coefData), .outValid(outValid), .y(y)
  );

  typedef struct { int due; int val; } pendT;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  int    coefM [DEG+1];
  pendT  q [$];
  int    lastY  = 0;
  bit    haveY  = 0;
  string curReq = "R5";

  function automatic int wrapW(longint v);
    logic [W-1:0] t;
    t = v[W-1:0];
    return int'($signed(t));
  endfunction

  function automatic int horner(int xv);
    longint acc;
    acc = coefM[DEG];
    for (int k = DEG - 1; k >= 0; k--) begin
      acc = wrapW((acc * xv) >>> F);
      acc = wrapW(acc + coefM[k]);
    end
    return int'(acc);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int xv, bit we, int addr, int data);
    @(negedge clk);
    inValid  = v;
    x        = xv[W-1:0];
    coefWe   = we;
    coefAddr = addr[AW-1:0];
    coefData = data[W-1:0];
    @(posedge clk);
    if (rst) begin
      q.delete();
      for (int k = 0; k <= DEG; k++) coefM[k] = 0;
    end else begin
      if (v)  q.push_back('{cyc + 2 * DEG, horner(xv)});
      if (we) coefM[addr] = wrapW(data);
    end
    cyc++;
    #1;
    if (q.size() > 0 && q[0].due == cyc) begin
      check(outValid == 1'b1, curReq, "outValid", int'(outValid), 1);
      check($signed(y) == q[0].val, curReq, "y", int'($signed(y)), q[0].val);
      lastY = q[0].val;
      haveY = 1;
      void'(q.pop_front());
    end else begin
      check(outValid == 1'b0, curReq, "outValid idle", int'(outValid), 0);
      if (haveY)
        check($signed(y) == lastY, "R6", "held y", int'($signed(y)), lastY);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic loadAll(int base, int stride);
    for (int k = 0; k <= DEG; k++) step(0, 0, 1, k, base + k * stride);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    inValid = 0; x = '0; coefWe = 0; coefAddr = '0; coefData = '0;

    // R5: reset state, then zero coefficients give zero
    curReq = "R5";
    idle(3);
    rst = 1'b0;
    step(1, 300, 0, 0, 0);
    idle(2 * DEG + 1);

    // R3: each index reaches its own coefficient; x = 1.0
    curReq = "R3";
    loadAll(-100, 64);
    step(1, 256, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, -256, 0, 0, 0);
    idle(2 * DEG + 1);

    // R1: latency of a lone sample
    curReq = "R1";
    step(1, 128, 0, 0, 0);
    n = 1;
    while (!outValid && n < 100) begin
      step(0, 0, 0, 0, 0);
      n++;
    end
    check(n == 2 * DEG, "R1", "latency", n, 2 * DEG);
    idle(2 * DEG + 1);

    // R2: back-to-back samples, signed values, then wrapping magnitudes
    curReq = "R2";
    for (int k = 0; k < 20; k++)
      step(1, int'($urandom_range(1200)) - 600, 0, 0, 0);
    loadAll(9000, 5000);
    for (int k = 0; k < 12; k++)
      step(1, int'($urandom_range(60000)) - 30000, 0, 0, 0);
    idle(2 * DEG + 1);

    // R7: bubbles keep their spacing
    curReq = "R7";
    loadAll(40, -30);
    for (int k = 0; k < 30; k++)
      step(bit'($urandom_range(1)), int'($urandom_range(1000)) - 500, 0, 0, 0);
    idle(2 * DEG + 1);

    // R4: writes while samples are in flight, one on the same edge
    curReq = "R4";
    for (int k = 0; k < 14; k++) begin
      if (k == 4)       step(1, 200 + k, 1, DEG, 700);
      else if (k == 7)  step(1, -150, 1, 0, -333);
      else if (k == 9)  step(1, 90, 1, 2, 512);
      else if (k == 11) step(0, 0, 1, 1, -77);
      else              step(1, 17 * k - 100, 0, 0, 0);
    end
    idle(2 * DEG + 1);

    // R5: reset drops samples in flight and clears coefficients
    curReq = "R5";
    for (int k = 0; k < 5; k++) step(1, 64 * k, 0, 0, 0);
    rst = 1'b1;
    step(0, 0, 0, 0, 0);
    rst = 1'b0;
    idle(2 * DEG + 2);
    step(1, 450, 0, 0, 0);
    idle(2 * DEG + 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule